// File: doc/BRIEF.md
# System Bus Priority Arbiter

This block decides which of four bus masters drives a shared system bus. Every rising clock edge it looks at the request lines and the lock lines and picks the master whose grant is shown in the following cycle. The four masters are ranked by index. Index 0 is the test-access master and has the highest rank. Index 1 is the print-engine control master, index 2 is the DMA master, and index 3 is the processor. The processor ranks lowest, but it is also the default master. It holds the grant through reset and whenever nobody is asking for the bus, so it can start a transfer without waiting.

Two mechanisms can raise the processor above the fixed ranking. The first is a programmable period timer. The second is a pending interrupt, which counts only when interrupt mode is switched on. A master that is granted and holds its lock line keeps the grant, whatever the other masters are asking for. A separate data-phase owner register follows the grant only on edges where the bus-ready input is high. The owner's lock flag is registered on those same edges. A small APB slave holds the control, period and status registers.

The grant path is one state machine with three states. PARK: the processor is granted because no request is present. OWN: a requesting master is granted by rank or by boost. HOLD: the granted master locked the bus. Every edge picks the next state as follows. The transition to HOLD is taken when the granted master's lock line is high. Otherwise the transition to PARK is taken when no request line is high. Otherwise the transition to OWN is taken. The boost timer is a second state machine, also with three states. IDLE: the timer is off. COUNT: the timer is loaded from the period register and counts down. PEND: the timer has expired and the boost is waiting. IDLE moves to COUNT when the timer becomes enabled. COUNT moves to PEND when the count runs out. PEND moves back to COUNT, reloading the period, once the processor holds the grant. Any state moves to IDLE when the enable bit is clear or the period is zero.

Top module: `sysbus_arbiter`

## Requirements
- R1: During and straight after reset, gnt_o is 4'b1000 (processor), owner_o is 3, owner_lock_o is 0, and the control and period registers read as 0.
- R2: When no lock holds and no boost is active, the grant shown one edge after sampling goes to the requesting master with the lowest index. Bit i of the one-hot gnt_o is master i.
- R3: If no request line is high and the granted master does not hold its lock, gnt_o becomes 4'b1000 at the next edge.
- R4: If lock_i[k] is high on an edge while master k is granted, the grant is unchanged after that edge. This takes precedence over requests and boosts. A lock line of a master that is not granted has no effect.
- R5: owner_o takes the index of the master granted before the edge, and owner_lock_o takes that master's lock line, only on edges with ready_i high. Otherwise both hold their value. gnt_o may change while ready_i is low.
- R6: With control bit 0 set and a non-zero period P, the timer counts P cycles and then makes the processor the top-ranked requester until it has been granted once, after which the timer reloads. With all four masters requesting, the processor is granted exactly one cycle in every P+2.
- R7: With a period of zero, or with control bit 0 clear, the processor gets no periodic boost.
- R8: With control bit 1 set, a high irq_i makes the processor the top-ranked requester. With bit 1 clear, irq_i has no effect.
- R9: APB registers are addressed by byte offset. Offset 0x00 is control: bit 0 enables the periodic boost and bit 1 enables interrupt mode, and the other bits read 0. Offset 0x04 is the period in cycles, bits 15:0. Offset 0x08 is read-only status: bits 1:0 give owner_o and bit 2 gives owner_lock_o, and writes to it are ignored. Any other offset reads 0. A write takes place on an edge where psel, penable and pwrite are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Bus request per master, bit i is master i |
| lock_i | input | 4 | Lock request per master |
| ready_i | input | 1 | Current transfer completes this cycle |
| irq_i | input | 1 | Pending interrupt for the processor |
| gnt_o | output | 4 | One-hot grant |
| owner_o | output | 2 | Index of the master owning the data phase |
| owner_lock_o | output | 1 | Lock state registered with owner_o |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that an APB access follows a setup cycle with an access cycle, and that the period register is changed only while the boost is disabled, or that a pending boost may be dropped when it changes. The bench drives every input on the falling edge and moves the period only through complete APB transfers. After any control change it lets a few cycles pass before it counts boost grants. Lock stimulus is applied both to the granted master and to masters that are not granted, so that the HOLD transition and its absence are both exercised.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int unsigned N_MST  = 4;
    localparam int unsigned MID_W  = $clog2(N_MST);
    typedef logic [MID_W-1:0] mid_t;
    localparam mid_t CPU_ID = mid_t'(N_MST - 1);

    typedef enum logic [1:0] {G_PARK, G_OWN, G_HOLD} gstate_e;
    typedef enum logic [1:0] {B_IDLE, B_COUNT, B_PEND} bstate_e;

    localparam int unsigned W_CTRL   = 0;
    localparam int unsigned W_PERIOD = 1;
    localparam int unsigned W_STATUS = 2;
    localparam int unsigned CTRL_PER = 0;
    localparam int unsigned CTRL_IRQ = 1;
endpackage

// File: rtl/arb_apb_regs.sv
module arb_apb_regs
    import arb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                psel_i,
    input  logic                penable_i,
    input  logic                pwrite_i,
    input  logic [ADDR_W-1:0]   paddr_i,
    input  logic [DATA_W-1:0]   pwdata_i,
    output logic [DATA_W-1:0]   prdata_o,
    input  mid_t                owner_i,
    input  logic                owner_lock_i,
    output logic                per_en_o,
    output logic                irq_en_o,
    output logic [PERIOD_W-1:0] period_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    logic                wr_en;
    logic                per_en_q, irq_en_q;
    logic [PERIOD_W-1:0] period_q;
    logic                unused_apb;

    assign word       = paddr_i[ADDR_W-1:2];
    assign wr_en      = psel_i && penable_i && pwrite_i;
    assign unused_apb = ^{paddr_i[1:0], pwdata_i[DATA_W-1:PERIOD_W]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            per_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            period_q <= '0;
        end else if (wr_en) begin
            if (word == WORD_W'(W_CTRL)) begin
                per_en_q <= pwdata_i[CTRL_PER];
                irq_en_q <= pwdata_i[CTRL_IRQ];
            end
            if (word == WORD_W'(W_PERIOD)) begin
                period_q <= pwdata_i[PERIOD_W-1:0];
            end
        end
    end

    always_comb begin
        prdata_o = '0;
        if (word == WORD_W'(W_CTRL)) begin
            prdata_o[CTRL_PER] = per_en_q;
            prdata_o[CTRL_IRQ] = irq_en_q;
        end else if (word == WORD_W'(W_PERIOD)) begin
            prdata_o[PERIOD_W-1:0] = period_q;
        end else if (word == WORD_W'(W_STATUS)) begin
            prdata_o[MID_W-1:0] = owner_i;
            prdata_o[MID_W]     = owner_lock_i;
        end
    end

    assign per_en_o = per_en_q;
    assign irq_en_o = irq_en_q;
    assign period_o = period_q;

    // R9: a period write lands on the next cycle
    p_period_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en && word == WORD_W'(W_PERIOD)) |=> period_q == $past(pwdata_i[PERIOD_W-1:0]));
endmodule

// File: rtl/arb_boost_timer.sv
module arb_boost_timer
    import arb_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                per_en_i,
    input  logic                irq_en_i,
    input  logic                irq_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                cpu_gnt_i,
    output logic                boost_o
);
    bstate_e             st_q, st_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;
    logic                active;

    assign active = per_en_i && (period_i != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= B_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            B_IDLE: begin
                if (active) begin
                    st_d  = B_COUNT;
                    cnt_d = period_i;
                end
            end
            B_COUNT: begin
                if (!active) begin
                    st_d = B_IDLE;
                end else if (cnt_q <= PERIOD_W'(1)) begin
                    st_d = B_PEND;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            B_PEND: begin
                if (!active) begin
                    st_d = B_IDLE;
                end else if (cpu_gnt_i) begin
                    st_d  = B_COUNT;
                    cnt_d = period_i;
                end
            end
            default: st_d = B_IDLE;
        endcase
    end

    always_comb begin
        boost_o = ((st_q == B_PEND) && !cpu_gnt_i) || (irq_en_i && irq_i);
    end

    // R6: a pending boost is retired once the processor holds the grant
    p_boost_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == B_PEND && cpu_gnt_i) |=> st_q != B_PEND);
    // R7: disabled or zero period leaves the timer idle
    p_timer_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active |=> st_q == B_IDLE);
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] lock_i,
    input  logic             ready_i,
    input  logic             boost_i,
    output logic [N_MST-1:0] gnt_o,
    output logic             cpu_gnt_o,
    output mid_t             owner_o,
    output logic             owner_lock_o
);
    gstate_e gst_q, gst_d;
    mid_t    gid_q, gid_d;
    mid_t    own_q;
    logic    own_lock_q;
    mid_t    pick;
    logic    held;

    assign held = lock_i[gid_q];

    always_comb begin
        pick = CPU_ID;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (req_i[i]) pick = mid_t'(i);
        end
        if (boost_i && req_i[CPU_ID]) pick = CPU_ID;
    end

    always_comb begin
        if (held) begin
            gst_d = G_HOLD;
            gid_d = gid_q;
        end else if (req_i == '0) begin
            gst_d = G_PARK;
            gid_d = CPU_ID;
        end else begin
            gst_d = G_OWN;
            gid_d = pick;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gst_q      <= G_PARK;
            gid_q      <= CPU_ID;
            own_q      <= CPU_ID;
            own_lock_q <= 1'b0;
        end else begin
            gst_q <= gst_d;
            gid_q <= gid_d;
            if (ready_i) begin
                own_q      <= gid_q;
                own_lock_q <= held;
            end
        end
    end

    always_comb begin
        for (int g = 0; g < N_MST; g++) begin
            gnt_o[g] = (gid_q == mid_t'(g));
        end
        cpu_gnt_o    = (gid_q == CPU_ID);
        owner_o      = own_q;
        owner_lock_o = own_lock_q;
    end

    p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gnt_o) == 1);
    p_park_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == '0 && !held) |=> gst_q == G_PARK && gnt_o[CPU_ID]);
    p_lock_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held |=> $stable(gnt_o));
    p_owner_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_i |=> $stable(owner_o) && $stable(owner_lock_o));
    // R6 and R8: an active boost puts a requesting processor on top
    p_boost_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boost_i && req_i[CPU_ID] && !held) |=> gnt_o[CPU_ID]);
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PERIOD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_MST-1:0]  req_i,
    input  logic [N_MST-1:0]  lock_i,
    input  logic              ready_i,
    input  logic              irq_i,
    output logic [N_MST-1:0]  gnt_o,
    output logic [MID_W-1:0]  owner_o,
    output logic              owner_lock_o,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DATA_W-1:0] pwdata_i,
    output logic [DATA_W-1:0] prdata_o
);
    logic                per_en, irq_en, boost, cpu_gnt;
    logic [PERIOD_W-1:0] period;
    mid_t                owner;
    logic                owner_lock;

    arb_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_regs (
        .clk_i, .rst_ni, .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
        .prdata_o, .owner_i(owner), .owner_lock_i(owner_lock),
        .per_en_o(per_en), .irq_en_o(irq_en), .period_o(period)
    );

    arb_boost_timer #(.PERIOD_W(PERIOD_W)) u_boost (
        .clk_i, .rst_ni, .per_en_i(per_en), .irq_en_i(irq_en), .irq_i,
        .period_i(period), .cpu_gnt_i(cpu_gnt), .boost_o(boost)
    );

    arb_grant_fsm u_grant (
        .clk_i, .rst_ni, .req_i, .lock_i, .ready_i, .boost_i(boost),
        .gnt_o, .cpu_gnt_o(cpu_gnt), .owner_o(owner), .owner_lock_o(owner_lock)
    );

    assign owner_o      = owner;
    assign owner_lock_o = owner_lock;
endmodule

// File: tb/sysbus_arbiter_tb.sv
module sysbus_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0, lock = '0;
    logic        ready = 1'b1, irq = 1'b0;
    logic [3:0]  gnt;
    logic [1:0]  owner;
    logic        owner_lock;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0, prdata, rd;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sysbus_arbiter u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lock_i(lock), .ready_i(ready),
        .irq_i(irq), .gnt_o(gnt), .owner_o(owner), .owner_lock_o(owner_lock),
        .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite), .paddr_i(paddr),
        .pwdata_i(pwdata), .prdata_o(prdata)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [3:0] lock;
        logic       irq;
        logic [3:0] exp;
    } vec_t;

    // R2 rank, R3 park, R4 lock, R8 irq ignored with mode off
    localparam vec_t VECS [15] = '{
        '{4'b1111, 4'b0000, 1'b0, 4'b0001},
        '{4'b1110, 4'b0000, 1'b0, 4'b0010},
        '{4'b1100, 4'b0000, 1'b0, 4'b0100},
        '{4'b1000, 4'b0000, 1'b0, 4'b1000},
        '{4'b0000, 4'b0000, 1'b0, 4'b1000},
        '{4'b0100, 4'b0000, 1'b0, 4'b0100},
        '{4'b0101, 4'b0100, 1'b0, 4'b0100},
        '{4'b0111, 4'b0100, 1'b0, 4'b0100},
        '{4'b0111, 4'b0000, 1'b0, 4'b0001},
        '{4'b0110, 4'b0010, 1'b0, 4'b0010},
        '{4'b0011, 4'b0010, 1'b0, 4'b0010},
        '{4'b1010, 4'b0000, 1'b0, 4'b0010},
        '{4'b1000, 4'b0000, 1'b1, 4'b1000},
        '{4'b1001, 4'b0000, 1'b1, 4'b0001},
        '{4'b0000, 4'b0000, 1'b0, 4'b1000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] id_of(input logic [3:0] oh);
        id_of = 2'd0;
        for (int k = 0; k < 4; k++) if (oh[k]) id_of = 2'(k);
    endfunction

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic step;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev;
        int hits, last, cyc;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", 32'(gnt), 32'h8);
        chk("R1 owner in reset", 32'(owner), 32'd3);
        chk("R1 owner lock in reset", 32'(owner_lock), 32'd0);
        rst_n = 1'b1;
        step();
        chk("R1 grant after reset", 32'(gnt), 32'h8);
        apb_rd(8'h00, rd); chk("R1 ctrl reset", rd, 32'h0);
        apb_rd(8'h04, rd); chk("R1 period reset", rd, 32'h0);

        // R9 register map
        apb_wr(8'h00, 32'hFFFF_FFFF); apb_rd(8'h00, rd); chk("R9 ctrl bits", rd, 32'h3);
        apb_wr(8'h04, 32'h0001_ABCD); apb_rd(8'h04, rd); chk("R9 period", rd, 32'hABCD);
        apb_wr(8'h08, 32'hFF);        apb_rd(8'h08, rd); chk("R9 status ro", rd, 32'h3);
        apb_rd(8'h0C, rd); chk("R9 unmapped", rd, 32'h0);
        apb_wr(8'h00, 32'h0); apb_wr(8'h04, 32'h0);

        prev = 2'd3;
        for (int i = 0; i < 15; i++) begin
            req = VECS[i].req; lock = VECS[i].lock; irq = VECS[i].irq;
            step();
            chk($sformatf("R2 table grant %0d", i), 32'(gnt), 32'(VECS[i].exp));
            chk($sformatf("R5 table owner %0d", i), 32'(owner), 32'(prev));
            prev = id_of(VECS[i].exp);
        end
        irq = 0;

        // R5 ready low freezes owner but not grant
        ready = 0; req = 4'b0010; lock = 0;
        step(); chk("R5 grant moves ready low", 32'(gnt), 32'h2);
        chk("R5 owner held", 32'(owner), 32'd0);
        step(); chk("R5 owner still held", 32'(owner), 32'd0);
        ready = 1; lock = 4'b0010;
        step(); chk("R5 owner update", 32'(owner), 32'd1);
        chk("R5 owner lock", 32'(owner_lock), 32'd1);
        chk("R4 locked grant", 32'(gnt), 32'h2);
        lock = 0; req = 0;
        step(); chk("R3 park", 32'(gnt), 32'h8);
        chk("R5 owner lock cleared", 32'(owner_lock), 32'd0);

        // R8 interrupt mode
        apb_wr(8'h00, 32'h2);
        req = 4'b1111; irq = 1;
        step(); chk("R8 irq boost", 32'(gnt), 32'h8);
        irq = 0;
        step(); chk("R8 irq released", 32'(gnt), 32'h1);
        apb_wr(8'h00, 32'h0);
        irq = 1;
        step(); step(); chk("R8 irq mode off", 32'(gnt), 32'h1);
        irq = 0;

        // R6 periodic boost
        apb_wr(8'h04, 32'd5);
        apb_wr(8'h00, 32'h1);
        hits = 0; last = -1;
        for (int c = 0; c < 70; c++) begin
            step();
            if (gnt == 4'h8) begin
                if (last >= 0) chk("R6 boost spacing", 32'(c - last), 32'd7);
                last = c; hits++;
            end
        end
        chk("R6 boost count", 32'(hits), 32'd10);
        req = 4'b0111;
        repeat (20) step();
        req = 4'b1111;
        step(); chk("R6 pending boost", 32'(gnt), 32'h8);
        step(); chk("R6 boost retired", 32'(gnt), 32'h1);

        // R7 zero period and disabled timer
        apb_wr(8'h04, 32'd0);
        repeat (3) step();
        hits = 0;
        for (int c = 0; c < 30; c++) begin step(); if (gnt == 4'h8) hits++; end
        chk("R7 zero period", 32'(hits), 32'd0);
        apb_wr(8'h04, 32'd5); apb_wr(8'h00, 32'h0);
        repeat (3) step();
        hits = 0;
        for (cyc = 0; cyc < 30; cyc++) begin step(); if (gnt == 4'h8) hits++; end
        chk("R7 disabled", 32'(hits), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule